// File: doc/BRIEF.md
# Transmit Character Mapper with Cell-Marker Insertion

This block sits between a parallel transmit input register and an 8B/10B encoder. Each incoming character word carries eight data bits and three flags: a control/data select, a start-of-cell flag and a violation flag. A word is taken in only when the sender's three-bit transmit address equals the strapped address of this channel and the transmit enable is high. Accepted words are held in a 16-entry FIFO.

The read side runs one character slot per clock. Each slot yields an 8-bit value and a K flag for the encoder. A word whose start-of-cell flag is set costs two slots. The first slot carries one of three cell-marker K characters. The second slot carries the word itself as a data character. A word with the violation flag set, and the start-of-cell flag clear, becomes a code-violation control character. When the FIFO is empty, the fill character K28.5 is sent.

Top module: `txCharMapper`

## Requirements
- R1: A word is written only in a cycle where txEnable is 1 and txAddr equals addrStrap. Any other word leaves the output stream unchanged.
- R2: While reset is held, the output reads 0xBC with the K flag set, and fifoFull is 0.
- R3: If startCell=0, violation=0 and ctrlSel=0, the word is sent as data. encValue carries the eight data bits and encK is 0.
- R4: If startCell=0, violation=0 and ctrlSel=1, the word is sent as a special character. encValue carries the eight data bits and encK is 1.
- R5: If startCell=0 and violation=1, the word is sent as the violation character C0.7, which is 0xE0 with encK=1. This holds for any ctrlSel and any data bits.
- R6: If startCell=1, the pair {ctrlSel, violation} selects the marker: 00 gives K23.7 (0xF7), 10 gives K27.7 (0xFB), and 01 or 11 gives K29.7 (0xFD). The marker is sent with encK=1. The word itself follows as data with encK=0.
- R7: The marker takes the slot just before the word it marks. The FIFO read is held for that one slot. A word written at clock edge n reaches the output at edge n+1 when the FIFO was empty, and its marker-free form, or its marker, is visible after that edge.
- R8: A slot that finds the FIFO empty sends K28.5 (0xBC) with encK=1.
- R9: The FIFO holds 16 words. fifoFull is 1 while it holds 16. A write attempted while fifoFull is 1 is dropped, even if a read frees a place in the same cycle.
- R10: Words leave in the order they were accepted. This holds when a write and a read fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-slot clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmit write enable |
| txAddr | input | 3 | Address presented with the write |
| addrStrap | input | 3 | Strapped address of this channel |
| txData | input | 8 | Character data bits |
| ctrlSel | input | 1 | 1 = special character, 0 = data |
| startCell | input | 1 | Start-of-cell flag; requests a marker |
| violation | input | 1 | Violation flag |
| encValue | output | 8 | Value presented to the encoder |
| encK | output | 1 | K-character flag to the encoder |
| fifoFull | output | 1 | FIFO holds 16 words |

## Verification
A write and a read can land in the same cycle. The sharpest case is a run of start-of-cell words written every cycle. Each of these words takes two read slots, so the FIFO fills while markers and held reads interleave with fresh writes. At one point a write meets a full FIFO in the very cycle a read frees a place. The bench records fifoFull before each write to decide whether that write should be kept. It then requires that the output hold exactly the kept words, in order, each one preceded by its marker.

// File: rtl/txmap_pkg.sv
package txmap_pkg;

  localparam logic [7:0] IDLE_CODE = 8'hBC;   // K28.5
  localparam logic [7:0] VIOL_CODE = 8'hE0;   // C0.7
  localparam logic [7:0] MARK_A    = 8'hF7;   // K23.7
  localparam logic [7:0] MARK_B    = 8'hFB;   // K27.7
  localparam logic [7:0] MARK_C    = 8'hFD;   // K29.7

  typedef struct packed {
    logic       startCell;
    logic       violation;
    logic       ctrlSel;
    logic [7:0] data;
  } charWordT;

  typedef struct packed {
    logic push;
    logic pop;
    logic loadMarker;
    logic loadChar;
    logic loadIdle;
  } ctrlStrobesT;

  function automatic logic [7:0] markerCode(charWordT w);
    case ({w.ctrlSel, w.violation})
      2'b00:   return MARK_A;
      2'b10:   return MARK_B;
      default: return MARK_C;
    endcase
  endfunction

  // returns {kFlag, value}
  function automatic logic [8:0] mapChar(charWordT w);
    if (w.startCell)      return {1'b0, w.data};
    else if (w.violation) return {1'b1, VIOL_CODE};
    else                  return {w.ctrlSel, w.data};
  endfunction

endpackage

// File: rtl/txMapCtrl.sv
module txMapCtrl
  import txmap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [ADDR_W-1:0] addrStrap,
  input  logic              headStartCell,
  output ctrlStrobesT       stb,
  output logic              fifoFull,
  output logic [CNT_W-1:0]  fillCount
);

  logic markerSent;
  logic fifoEmpty;
  logic [CNT_W-1:0] fillNext;

  assign fifoFull  = (fillCount == CNT_W'(DEPTH));
  assign fifoEmpty = (fillCount == '0);

  always_comb begin
    stb = '0;
    stb.push = txEnable && (txAddr == addrStrap) && !fifoFull;
    if (fifoEmpty) begin
      stb.loadIdle = 1'b1;
    end else if (headStartCell && !markerSent) begin
      stb.loadMarker = 1'b1;
    end else begin
      stb.loadChar = 1'b1;
      stb.pop      = 1'b1;
    end
  end

  assign fillNext = fillCount + CNT_W'(stb.push) - CNT_W'(stb.pop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount  <= '0;
      markerSent <= 1'b0;
    end else begin
      fillCount <= fillNext;
      if (stb.loadMarker)  markerSent <= 1'b1;
      else if (stb.pop)    markerSent <= 1'b0;
    end
  end

endmodule

// File: rtl/txMapDatapath.sv
module txMapDatapath
  import txmap_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobesT stb,
  input  charWordT    inWord,
  output logic        headStartCell,
  output logic [7:0]  encValue,
  output logic        encK
);

  charWordT         mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  charWordT         headWord;
  logic [8:0]       mapped;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign headWord      = mem[rdPtr];
  assign headStartCell = headWord.startCell;
  assign mapped        = mapChar(headWord);

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= inWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      encValue <= IDLE_CODE;
      encK     <= 1'b1;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      if (stb.loadMarker) begin
        encValue <= markerCode(headWord);
        encK     <= 1'b1;
      end else if (stb.loadChar) begin
        encValue <= mapped[7:0];
        encK     <= mapped[8];
      end else if (stb.loadIdle) begin
        encValue <= IDLE_CODE;
        encK     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/txCharMapper.sv
module txCharMapper
  import txmap_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [ADDR_W-1:0] txAddr,
  input  logic [ADDR_W-1:0] addrStrap,
  input  logic [7:0]        txData,
  input  logic              ctrlSel,
  input  logic              startCell,
  input  logic              violation,
  output logic [7:0]        encValue,
  output logic              encK,
  output logic              fifoFull
);

  ctrlStrobesT      stb;
  charWordT         inWord;
  logic             headStartCell;
  logic [CNT_W-1:0] fillCount;

  assign inWord = '{startCell: startCell, violation: violation,
                    ctrlSel: ctrlSel, data: txData};

  txMapCtrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txAddr(txAddr),
    .addrStrap(addrStrap), .headStartCell(headStartCell),
    .stb(stb), .fifoFull(fifoFull), .fillCount(fillCount)
  );

  txMapDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inWord(inWord),
    .headStartCell(headStartCell), .encValue(encValue), .encK(encK)
  );

endmodule

// File: rtl/txCharMapperChk.sv
module txCharMapperChk #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              txEnable,
  input logic [ADDR_W-1:0] txAddr,
  input logic [ADDR_W-1:0] addrStrap,
  input logic              fifoFull,
  input logic [7:0]        encValue,
  input logic              encK,
  input logic [CNT_W-1:0]  fillCount,
  input logic              pushStb,
  input logic              popStb,
  input logic              markerStb
);

  // R1
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable || txAddr != addrStrap) |-> !pushStb);

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !pushStb);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    popStb |-> fillCount != '0);

  // R7
  marker_then_char_chk: assert property (@(posedge clk) disable iff (!rstN)
    markerStb |=> (popStb && encK &&
                   (encValue == 8'hF7 || encValue == 8'hFB || encValue == 8'hFD)));

  // R8
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |=> (encK && encValue == 8'hBC));

  // R10
  count_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushStb && !popStb) |=> fillCount == $past(fillCount) + 1'b1);

endmodule

bind txCharMapper txCharMapperChk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .txAddr(txAddr),
  .addrStrap(addrStrap), .fifoFull(fifoFull), .encValue(encValue),
  .encK(encK), .fillCount(fillCount), .pushStb(stb.push),
  .popStb(stb.pop), .markerStb(stb.loadMarker)
);

// File: tb/txCharMapper_test.sv
module txCharMapper_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEnable = 1'b0;
  logic [2:0] txAddr = 3'd0;
  logic [2:0] addrStrap = 3'd5;
  logic [7:0] txData = 8'h00;
  logic       ctrlSel = 1'b0;
  logic       startCell = 1'b0;
  logic       violation = 1'b0;
  logic [7:0] encValue;
  logic       encK;
  logic       fifoFull;

  int checks = 0;
  int failures = 0;
  logic       capEn = 1'b0;
  logic [8:0] capQ[$];

  always #4 clk = ~clk;   // 125 MHz

  txCharMapper uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txAddr(txAddr),
    .addrStrap(addrStrap), .txData(txData), .ctrlSel(ctrlSel),
    .startCell(startCell), .violation(violation),
    .encValue(encValue), .encK(encK), .fifoFull(fifoFull)
  );

  always @(negedge clk) if (capEn) capQ.push_back({encK, encValue});

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit en, input logic [2:0] a, input bit sc,
                       input bit sv, input bit cd, input logic [7:0] d);
    @(negedge clk);
    txEnable = en; txAddr = a; startCell = sc; violation = sv;
    ctrlSel = cd; txData = d;
  endtask

  task automatic quiet();
    @(negedge clk);
    txEnable = 1'b0;
  endtask

  task automatic startCap();
    capQ.delete();
    capEn = 1'b1;
  endtask

  // stop capture after n cycles and return the non-idle entries
  task automatic stopCap(input int n, output logic [8:0] got[$]);
    repeat (n) @(negedge clk);
    capEn = 1'b0;
    got.delete();
    foreach (capQ[i]) if (capQ[i] != 9'h1BC) got.push_back(capQ[i]);
  endtask

  task automatic compareStream(input string tag, input logic [8:0] got[$],
                               input logic [8:0] exp[$]);
    check(got.size() == exp.size(), {tag, " length"}, got.size(), exp.size());
    foreach (exp[i])
      if (i < got.size()) check(got[i] == exp[i], tag, got[i], exp[i]);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(encValue == 8'hBC && encK, "R2 reset output", {encK, encValue}, 9'h1BC);
    check(!fifoFull, "R2 reset full", fifoFull, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(encValue == 8'hBC && encK, "R8 idle when empty", {encK, encValue}, 9'h1BC);
  endtask

  task automatic testAddrGate();
    logic [8:0] got[$];
    logic [8:0] exp[$];
    startCap();
    drive(1, 3'd4, 0, 0, 0, 8'h11);    // wrong address
    drive(0, 3'd5, 0, 0, 0, 8'h22);    // enable low
    drive(1, 3'd5, 0, 0, 0, 8'h33);    // accepted
    quiet();
    stopCap(6, got);
    exp = '{9'h033};
    compareStream("R1 address/enable gate", got, exp);
  endtask

  task automatic testPlain();
    logic [8:0] got[$];
    logic [8:0] exp[$];
    startCap();
    drive(1, 3'd5, 0, 0, 0, 8'hA5);
    drive(1, 3'd5, 0, 0, 1, 8'h3C);
    drive(1, 3'd5, 0, 0, 0, 8'h00);
    quiet();
    stopCap(6, got);
    exp = '{9'h0A5, 9'h13C, 9'h000};
    compareStream("R3 R4 R10 data and special", got, exp);
  endtask

  task automatic testViolation();
    logic [8:0] got[$];
    logic [8:0] exp[$];
    startCap();
    drive(1, 3'd5, 0, 1, 1, 8'h55);
    drive(1, 3'd5, 0, 1, 0, 8'hAA);
    quiet();
    stopCap(6, got);
    exp = '{9'h1E0, 9'h1E0};
    compareStream("R5 violation override", got, exp);
  endtask

  task automatic testMarkers();
    logic [8:0] got[$];
    logic [8:0] exp[$];
    startCap();
    drive(1, 3'd5, 1, 0, 0, 8'h01);
    drive(1, 3'd5, 1, 0, 1, 8'h02);
    drive(1, 3'd5, 1, 1, 0, 8'h03);
    drive(1, 3'd5, 1, 1, 1, 8'h04);
    quiet();
    stopCap(12, got);
    exp = '{9'h1F7, 9'h001, 9'h1FB, 9'h002, 9'h1FD, 9'h003, 9'h1FD, 9'h004};
    compareStream("R6 marker selection", got, exp);
  endtask

  task automatic testMarkerTiming();
    // write lands at edge E1; marker after E2, char after E3, idle after E4
    drive(1, 3'd5, 1, 0, 0, 8'h7E);
    @(posedge clk);
    #1 txEnable = 1'b0;
    @(negedge clk);
    check({encK, encValue} == 9'h1BC, "R7 slot before marker", {encK, encValue}, 9'h1BC);
    @(negedge clk);
    check({encK, encValue} == 9'h1F7, "R7 marker slot", {encK, encValue}, 9'h1F7);
    @(negedge clk);
    check({encK, encValue} == 9'h07E, "R7 char follows marker", {encK, encValue}, 9'h07E);
    @(negedge clk);
    check({encK, encValue} == 9'h1BC, "R8 idle after drain", {encK, encValue}, 9'h1BC);
  endtask

  task automatic testFull();
    logic [8:0] got[$];
    logic [8:0] exp[$];
    int dropped = 0;
    bit sawFull = 0;
    startCap();
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (fifoFull) begin
        sawFull = 1;
        dropped++;
      end else begin
        exp.push_back(9'h1F7);
        exp.push_back({1'b0, 8'(i)});
      end
      txEnable = 1'b1; txAddr = 3'd5; startCell = 1'b1; violation = 1'b0;
      ctrlSel = 1'b0; txData = 8'(i);
    end
    quiet();
    stopCap(60, got);
    check(sawFull, "R9 full flag reached", sawFull, 1);
    check(dropped > 0, "R9 writes dropped while full", dropped, 1);
    compareStream("R9 R10 kept words in order", got, exp);
    check(!fifoFull && {encK, encValue} == 9'h1BC, "R8 idle after full drain",
          {fifoFull, encK, encValue}, 10'h1BC);
  endtask

  initial begin
    testReset();
    testAddrGate();
    testPlain();
    testViolation();
    testMarkers();
    testMarkerTiming();
    testFull();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule